// File: doc/BRIEF.md
# Type-C Sink CC Attach Classifier

This block runs a sink-side USB Type-C port without interrupts. On a fixed polling period it works out whether a source is attached on CC1 or CC2. It also works out which current level that source advertises: Default, 1.5 A or 3.0 A. It does not measure voltages directly. Each cycle it drives a comparator threshold code to an external analog front end, waits for the comparators to settle, and samples one flag per CC line. It then raises the threshold and compares the new flags with the flags from the step before. A flag that drops between two levels places the line's voltage between those levels.

A cycle first probes at threshold code 2. If neither flag is set, the port is unattached and the cycle ends there. If a flag is set, the sequencer waits long enough for any Power Delivery traffic to finish. It then probes at code 4, and at code 6 only if code 4 did not decide the result. The pull-up current field stays off throughout, since the port acts only as a sink. The decoded level of each line is held on its output. A one-cycle strobe marks any cycle whose result differs from the result held when that cycle began.

Top module: `cc_attach_classifier`

## Requirements
- R1: While reset is asserted, and right after it, both CC levels read Open (code 0), the change strobe is low and the whole control word is zero.
- R2: A measurement cycle starts every PERIOD_TICKS clocks. A cycle starts when the threshold field goes from 0 to code 2. Results change only at the end of a cycle.
- R3: Each threshold code is held for at least SETTLE_TICKS clocks before the flags are judged at that code. Codes 4 and 6 are each held for exactly SETTLE_TICKS clocks.
- R4: At code 2, if neither flag is set, both lines are reported Open (0). The cycle ends after SETTLE_TICKS clocks, and codes 4 and 6 are never driven.
- R5: At code 2, if either flag is set, code 2 stays on the control word for SETTLE_TICKS + PD_WAIT_TICKS clocks before code 4 is driven.
- R6: At code 4, CC1 is tested first. If CC1 was set at code 2 and is clear now, the result is CC1 Default (1) and CC2 Open (0). Otherwise, if CC2 was set at code 2 and is clear now, the result is CC1 Open and CC2 Default. With either result the cycle ends without code 6. Code 6 is only ever entered from code 4.
- R7: At code 6, each line is compared with its flag at code 4, CC1 first. A line that was set is 1.5 A (2) if its flag is now clear, or 3.0 A (3) if it is still set. The other line is reported Open.
- R8: Control word layout: threshold code in bits 10:8, taking only 0, 2, 4 or 6. The pull-up current select sits in bits 13:12 and is always 0 (off); all other bits are 0. The comparator flag input carries CC2 on bit 4 and CC1 on bit 3.
- R9: The change strobe is high for exactly one clock at the end of a cycle whose result differs from the result at the cycle's start. It stays low when the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Polling clock (nominally 32 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_flags | input | 2 | Comparator flags, bit 4 = CC2, bit 3 = CC1 |
| phy_ctrl | output | 14 | Control word to the analog front end |
| cc1_level | output | 2 | CC1 level: 0 Open, 1 Default, 2 1.5 A, 3 3.0 A |
| cc2_level | output | 2 | CC2 level, same coding |
| cc_change | output | 1 | One-clock strobe when the result moves |

## Verification
The bench models each CC line as a voltage index. A flag reads high while that index is above the driven threshold code, so the flags follow the sequencer closely, as a real comparator would. The vectors cover these cases:
- An unattached port, and a line held below the first threshold.
- A Default source on either line.
- 1.5 A and 3.0 A sources on either line.
- Both lines high at once, at equal and unequal levels, which shows that CC1 takes priority at both code 4 and code 6.

Repeated vectors show that the strobe stays low when the result does not move. For each cycle the bench also measures how long each threshold code is driven. This shows the early exit, the Power Delivery wait, the settling windows and the polling period.

// File: rtl/cc_cls_pkg.sv
package cc_cls_pkg;

  typedef enum logic [1:0] {
    CC_OPEN = 2'd0,
    CC_DEF  = 2'd1,
    CC_1A5  = 2'd2,
    CC_3A0  = 2'd3
  } cc_lvl_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LVL2   = 3'd1,
    ST_PDWAIT = 3'd2,
    ST_LVL4   = 3'd3,
    ST_LVL6   = 3'd4
  } seq_st_t;

  localparam int          CTRL_W   = 14;
  localparam int          FLAG_CC1 = 3;
  localparam int          FLAG_CC2 = 4;
  localparam logic [1:0]  PU_OFF   = 2'd0;
  localparam logic [2:0]  THR_LO   = 3'd2;
  localparam logic [2:0]  THR_MID  = 3'd4;
  localparam logic [2:0]  THR_HI   = 3'd6;

  // threshold code presented while the sequencer sits in a given step
  function automatic logic [2:0] thr_of(seq_st_t st);
    case (st)
      ST_LVL2, ST_PDWAIT: thr_of = THR_LO;
      ST_LVL4:            thr_of = THR_MID;
      ST_LVL6:            thr_of = THR_HI;
      default:            thr_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cc_poll_timer.sv
module cc_poll_timer #(
  parameter int PERIOD_TICKS = 3200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    cnt_d = tick ? CW'(PERIOD_TICKS - 1) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(PERIOD_TICKS - 1);
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cc_step_seq.sv
module cc_step_seq
  import cc_cls_pkg::*;
#(
  parameter int SETTLE_TICKS  = 18,
  parameter int PD_WAIT_TICKS = 960
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cur_flags,   // [0] = CC1, [1] = CC2
  input  logic       match,
  output seq_st_t    state,
  output logic [1:0] old_flags,
  output logic       sample,
  output logic [2:0] thr_code
);
  localparam int MAXW = (SETTLE_TICKS > PD_WAIT_TICKS) ? SETTLE_TICKS : PD_WAIT_TICKS;
  localparam int WW   = $clog2(MAXW + 1);
  localparam logic [WW-1:0] LD_SETTLE = WW'(SETTLE_TICKS - 1);
  localparam logic [WW-1:0] LD_PD     = WW'(PD_WAIT_TICKS - 1);

  seq_st_t     st_q, st_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [1:0]  old_q, old_d;
  logic        done;

  assign done      = (wait_q == '0);
  assign state     = st_q;
  assign old_flags = old_q;
  assign thr_code  = thr_of(st_q);
  assign sample    = done && (st_q == ST_LVL2 || st_q == ST_LVL4 || st_q == ST_LVL6);

  always_comb begin
    st_d   = st_q;
    wait_d = done ? wait_q : wait_q - 1'b1;
    old_d  = old_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_LVL2;
        wait_d = LD_SETTLE;
      end
      ST_LVL2: if (done) begin
        if (match) st_d = ST_IDLE;
        else begin
          st_d   = ST_PDWAIT;
          wait_d = LD_PD;
          old_d  = cur_flags;
        end
      end
      ST_PDWAIT: if (done) begin
        st_d   = ST_LVL4;
        wait_d = LD_SETTLE;
      end
      ST_LVL4: if (done) begin
        if (match) st_d = ST_IDLE;
        else begin
          st_d   = ST_LVL6;
          wait_d = LD_SETTLE;
          old_d  = cur_flags;
        end
      end
      ST_LVL6: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      old_q  <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      old_q  <= old_d;
    end
  end

  // independent dwell counter: cycles the current threshold code has been driven
  logic [WW-1:0] hold_q, hold_d;
  always_comb begin
    if (thr_of(st_d) != thr_code) hold_d = '0;
    else if (32'(hold_q) < MAXW)  hold_d = hold_q + 1'b1;
    else                          hold_d = hold_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  AST_SETTLED_BEFORE_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (32'(hold_q) + 1 >= SETTLE_TICKS)); // R3

endmodule

// File: rtl/cc_step_decode.sv
module cc_step_decode
  import cc_cls_pkg::*;
(
  input  seq_st_t    state,
  input  logic [1:0] old_flags,   // [0] = CC1, [1] = CC2
  input  logic [1:0] cur_flags,
  output logic       match,
  output cc_lvl_t    res1,
  output cc_lvl_t    res2
);
  always_comb begin
    match = 1'b0;
    res1  = CC_OPEN;
    res2  = CC_OPEN;
    case (state)
      ST_LVL2: match = (cur_flags == 2'b00);
      ST_LVL4: begin
        if (old_flags[0] && !cur_flags[0]) begin
          match = 1'b1;
          res1  = CC_DEF;
        end else if (old_flags[1] && !cur_flags[1]) begin
          match = 1'b1;
          res2  = CC_DEF;
        end
      end
      ST_LVL6: begin
        if (old_flags[0]) begin
          match = 1'b1;
          res1  = cur_flags[0] ? CC_3A0 : CC_1A5;
        end else if (old_flags[1]) begin
          match = 1'b1;
          res2  = cur_flags[1] ? CC_3A0 : CC_1A5;
        end
      end
      default: match = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_result_reg.sv
module cc_result_reg
  import cc_cls_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    commit,
  input  cc_lvl_t res1,
  input  cc_lvl_t res2,
  output cc_lvl_t cc1,
  output cc_lvl_t cc2,
  output logic    chg
);
  cc_lvl_t c1_q, c2_q, c1_d, c2_d;
  cc_lvl_t p1_q, p2_q, p1_d, p2_d;
  logic    chg_q, chg_d;

  always_comb begin
    c1_d  = commit ? res1 : c1_q;
    c2_d  = commit ? res2 : c2_q;
    p1_d  = start ? c1_q : p1_q;
    p2_d  = start ? c2_q : p2_q;
    chg_d = commit && ((res1 != p1_q) || (res2 != p2_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q  <= CC_OPEN;
      c2_q  <= CC_OPEN;
      p1_q  <= CC_OPEN;
      p2_q  <= CC_OPEN;
      chg_q <= 1'b0;
    end else begin
      c1_q  <= c1_d;
      c2_q  <= c2_d;
      p1_q  <= p1_d;
      p2_q  <= p2_d;
      chg_q <= chg_d;
    end
  end

  assign cc1 = c1_q;
  assign cc2 = c2_q;
  assign chg = chg_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |=> !chg_q); // R9
  AST_STROBE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> ((c1_q != p1_q) || (c2_q != p2_q))); // R9

endmodule

// File: rtl/cc_attach_classifier.sv
module cc_attach_classifier
  import cc_cls_pkg::*;
#(
  parameter int PERIOD_TICKS  = 3200,
  parameter int SETTLE_TICKS  = 18,
  parameter int PD_WAIT_TICKS = 960
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FLAG_CC2:FLAG_CC1]   cmp_flags,
  output logic [CTRL_W-1:0]          phy_ctrl,
  output logic [1:0]                 cc1_level,
  output logic [1:0]                 cc2_level,
  output logic                       cc_change
);
  logic       tick, start, sample, match, commit;
  seq_st_t    state;
  logic [1:0] old_flags, cur_flags;
  logic [2:0] thr_code;
  cc_lvl_t    res1, res2, cc1, cc2;

  assign cur_flags = {cmp_flags[FLAG_CC2], cmp_flags[FLAG_CC1]};
  assign start     = tick && (state == ST_IDLE);
  assign commit    = sample && match;

  cc_poll_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  cc_step_seq #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .PD_WAIT_TICKS(PD_WAIT_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cur_flags(cur_flags),
    .match    (match),
    .state    (state),
    .old_flags(old_flags),
    .sample   (sample),
    .thr_code (thr_code)
  );

  cc_step_decode u_dec (
    .state    (state),
    .old_flags(old_flags),
    .cur_flags(cur_flags),
    .match    (match),
    .res1     (res1),
    .res2     (res2)
  );

  cc_result_reg u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .commit(commit),
    .res1  (res1),
    .res2  (res2),
    .cc1   (cc1),
    .cc2   (cc2),
    .chg   (cc_change)
  );

  // bits 13:12 pull-up select, bit 11 spare, bits 10:8 threshold, 7:0 spare
  assign phy_ctrl  = {PU_OFF, 1'b0, thr_code, 8'h00};
  assign cc1_level = cc1;
  assign cc2_level = cc2;

  AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl[10:8] == 3'd0 || phy_ctrl[10:8] == THR_LO ||
     phy_ctrl[10:8] == THR_MID || phy_ctrl[10:8] == THR_HI)); // R8
  AST_PULLUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl[13:12] == 2'd0) && (phy_ctrl[11] == 1'b0) && (phy_ctrl[7:0] == 8'h00)); // R8
  AST_HI_AFTER_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl[10:8] == THR_HI && $past(phy_ctrl[10:8]) != THR_HI)
      |-> ($past(phy_ctrl[10:8]) == THR_MID)); // R6
  AST_RESULT_AT_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    ({cc1_level, cc2_level} != $past({cc1_level, cc2_level}))
      |-> ($past(phy_ctrl[10:8]) != 3'd0)); // R2

endmodule

// File: tb/sim_cc_attach_classifier.sv
`timescale 1ns/1ps
module sim_cc_attach_classifier;
  localparam int PER = 40;
  localparam int SET = 3;
  localparam int PDW = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  v1, v2;
  logic [4:3]  flags;
  logic [13:0] phy_ctrl;
  logic [1:0]  cc1_level, cc2_level;
  logic        cc_change;
  logic [2:0]  thr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign thr   = phy_ctrl[10:8];
  assign flags = {(v2 > thr), (v1 > thr)};   // bit 4 = CC2, bit 3 = CC1

  cc_attach_classifier #(
    .PERIOD_TICKS (PER),
    .SETTLE_TICKS (SET),
    .PD_WAIT_TICKS(PDW)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_flags(flags),
    .phy_ctrl (phy_ctrl),
    .cc1_level(cc1_level),
    .cc2_level(cc2_level),
    .cc_change(cc_change)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {v1, v2, expected cc1, expected cc2}; level code 0 Open,1 Def,2 1.5A,3 3.0A
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {3'd0, 3'd0, 2'd0, 2'd0},
    {3'd3, 3'd0, 2'd1, 2'd0},
    {3'd3, 3'd0, 2'd1, 2'd0},
    {3'd0, 3'd3, 2'd0, 2'd1},
    {3'd3, 3'd7, 2'd1, 2'd0},
    {3'd7, 3'd3, 2'd0, 2'd1},
    {3'd5, 3'd7, 2'd2, 2'd0},
    {3'd7, 3'd5, 2'd3, 2'd0},
    {3'd0, 3'd5, 2'd0, 2'd2},
    {3'd0, 3'd7, 2'd0, 2'd3},
    {3'd7, 3'd7, 2'd3, 2'd0},
    {3'd5, 3'd5, 2'd2, 2'd0},
    {3'd0, 3'd0, 2'd0, 2'd0},
    {3'd1, 3'd2, 2'd0, 2'd0}
  };

  int l2, l4, l6, pulses, t_start;
  int ctrl_bad = 0;

  always @(negedge clk)
    if (rst_n && (phy_ctrl[13:11] != 3'd0 || phy_ctrl[7:0] != 8'd0 || thr[0] != 1'b0))
      ctrl_bad++;

  task automatic run_cycle();
    l2 = 0; l4 = 0; l6 = 0; pulses = 0;
    do @(negedge clk); while (thr == 3'd0);
    t_start = cyc;
    while (thr != 3'd0) begin
      if (thr == 3'd2) l2++;
      if (thr == 3'd4) l4++;
      if (thr == 3'd6) l6++;
      if (cc_change) pulses++;
      @(negedge clk);
    end
    if (cc_change) pulses++;
    @(negedge clk);
    if (cc_change) pulses++;   // a wider strobe would be counted twice
  endtask

  initial begin
    rst_n = 1'b0;
    v1 = 3'd0; v2 = 3'd0;
    repeat (3) @(negedge clk);
    chk(cc1_level == 2'd0 && cc2_level == 2'd0, "R1 levels in reset", {cc1_level, cc2_level}, 0);
    chk(phy_ctrl == 14'd0 && !cc_change, "R1 ctrl/strobe in reset", int'(phy_ctrl), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cc1_level == 2'd0 && cc2_level == 2'd0 && !cc_change, "R1 after release",
        {cc1_level, cc2_level, cc_change}, 0);

    begin
      logic [1:0] pe1, pe2;
      int last_start;
      pe1 = 2'd0; pe2 = 2'd0; last_start = -1;
      for (int i = 0; i < NV; i++) begin
        logic [1:0] e1, e2;
        bit open_all, dec4;
        v1 = VEC[i][9:7];
        v2 = VEC[i][6:4];
        e1 = VEC[i][3:2];
        e2 = VEC[i][1:0];
        open_all = (e1 == 2'd0 && e2 == 2'd0);
        dec4     = (e1 == 2'd1 || e2 == 2'd1);
        run_cycle();
        chk(cc1_level == e1, dec4 ? "R6 cc1" : "R7 cc1", cc1_level, e1);
        chk(cc2_level == e2, dec4 ? "R6 cc2" : "R7 cc2", cc2_level, e2);
        chk(pulses == (({e1, e2} != {pe1, pe2}) ? 1 : 0), "R9 strobe count",
            pulses, ({e1, e2} != {pe1, pe2}) ? 1 : 0);
        if (open_all) begin
          chk(l2 == SET, "R4 code2 length", l2, SET);
          chk(l4 == 0 && l6 == 0, "R4 no higher codes", l4 + l6, 0);
        end else begin
          chk(l2 == SET + PDW, "R5 code2 plus pd wait", l2, SET + PDW);
          chk(l4 == SET, "R3 code4 settle", l4, SET);
          chk(l6 == (dec4 ? 0 : SET), dec4 ? "R6 early exit" : "R3 code6 settle",
              l6, dec4 ? 0 : SET);
        end
        if (last_start >= 0)
          chk(t_start - last_start == PER, "R2 period", t_start - last_start, PER);
        last_start = t_start;
        pe1 = e1; pe2 = e2;
      end
    end

    chk(ctrl_bad == 0, "R8 control word layout", ctrl_bad, 0);

    // reset in the middle of a cycle
    v1 = 3'd7; v2 = 3'd7;
    do @(negedge clk); while (thr == 3'd0);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(phy_ctrl == 14'd0 && cc1_level == 2'd0 && cc2_level == 2'd0 && !cc_change,
        "R1 mid-cycle reset", int'(phy_ctrl), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_cycle();
    chk(cc1_level == 2'd3 && cc2_level == 2'd0, "R7 after re-reset", cc1_level, 3);
    chk(pulses == 1, "R9 strobe after re-reset", pulses, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule